// File: doc/BRIEF.md
# Sectored Second-Level Cache Tag Controller

This block is the tag-and-status half of a unified, write-back second-level cache. Five requesters share it: the instruction fetch path, the data path with one load slot and two store slots, and a bus snoop port. Each cycle a fixed-priority arbiter picks one pending request. The controller then looks it up in a two-way set-associative tag array. Every line in that array is split into 32-byte sectors, and each sector keeps its own valid and modified bit. A hit is handed to the data RAM port as a one-cycle service pulse that carries the way. A miss is forwarded toward the bus as a miss request. Before that miss request goes out, any modified sectors of the victim line are sent as writeback requests, one per cycle.

Addresses are sector addresses, meaning the byte address divided by 32, laid out as `{tag, set, sector}`. A line holds 64 or 128 bytes, which gives two or four sectors. The tag and status of the new line are written at the moment the miss is issued. The data return over the bus is outside this block.

Snoops never allocate and never touch the replacement state. A snoop that hits a sector invalidates it. If that sector was modified, the snoop also reports it as dirty, so the system can source the data before the copy is dropped.

Top module: `l2t_ctrl_top`

## Requirements
- R1: After reset every ack, service, writeback, miss and snoop-dirty output is low, and every sector of every line is invalid, so the first access to any address misses.
- R2: A non-snoop request that hits a valid sector raises its ack, `svc_valid`, the hit way on `svc_way` and its address on `svc_addr` exactly one cycle after it is granted. No writeback or miss request is raised for it.
- R3: At most one ack is high in any cycle. When several requests are pending, the snoop is granted first, then the data requests, then the instruction fetch. A requester whose ack is high that cycle is not granted again.
- R4: Within the data requests the load goes before both store slots. Of two pending stores the one that became pending first is served first. Stores that became pending in the same cycle are served slot 0 first.
- R5: A non-snoop request that misses on a line that is not present, with no modified victim sectors, raises `miss_valid` with its address and its ack in the same cycle, two cycles after the grant. `svc_valid` stays low.
- R6: Each set keeps one replacement bit that names the way to evict. A hit or a fill sets it to the other way, and a miss on an absent line replaces the way it names.
- R7: Before the miss request, each victim sector that is both valid and modified is sent on `wb_valid`/`wb_addr` as `{victim tag, set, sector}`. They go out one per cycle, lowest sector first, so the ack comes 2 + (number of writebacks) cycles after the grant.
- R8: A store hit sets that sector's modified bit and raises `svc_write`. A store miss fills the sector as modified and raises `miss_write`.
- R9: A snoop is acknowledged one cycle after its grant. On a hit it invalidates the sector and raises `snoop_dirty` only if the sector was modified. On a miss nothing changes. A snoop never raises `svc_valid`, a writeback or a miss request.
- R10: A miss on an invalid sector of a line that is already present fills that sector into the same way. It sends no writeback and keeps the other sectors' status.
- R11: A fill into a newly allocated line makes only the requested sector valid and clears the others. The sector index is the low `log2(LINE_BYTES/32)` address bits, and the set index is the bits above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ifetch_req | input | 1 | Instruction fetch request, held until acked |
| ifetch_addr | input | ADDR_W | Instruction fetch sector address |
| ifetch_ack | output | 1 | Instruction fetch done |
| load_req | input | 1 | Load request, held until acked |
| load_addr | input | ADDR_W | Load sector address |
| load_ack | output | 1 | Load done |
| store0_req | input | 1 | Store slot 0 request |
| store0_addr | input | ADDR_W | Store slot 0 sector address |
| store0_ack | output | 1 | Store slot 0 done |
| store1_req | input | 1 | Store slot 1 request |
| store1_addr | input | ADDR_W | Store slot 1 sector address |
| store1_ack | output | 1 | Store slot 1 done |
| snoop_req | input | 1 | Bus snoop request |
| snoop_addr | input | ADDR_W | Snooped sector address |
| snoop_ack | output | 1 | Snoop done |
| snoop_dirty | output | 1 | Snoop hit a modified sector (with snoop_ack) |
| svc_valid | output | 1 | Hit serviced from data array |
| svc_way | output | 1 | Way holding the hit |
| svc_write | output | 1 | Serviced hit is a store |
| svc_addr | output | ADDR_W | Sector address of the hit |
| wb_valid | output | 1 | Writeback of a modified victim sector |
| wb_addr | output | ADDR_W | Sector address being written back |
| miss_valid | output | 1 | Miss forwarded to the bus |
| miss_write | output | 1 | Forwarded miss is a store |
| miss_addr | output | ADDR_W | Sector address of the miss |

## Verification
A small configuration with 4 sets, 2 sectors per line and 3-bit tags lets the bench walk every one of the 64 sector addresses. The walks use instruction fetches, then loads in reverse, then alternating store slots on a scrambled order, then a mixed stream with snoops. Together these patterns separate four kinds of access: a clean hit, a sector miss on a resident line, a miss with a clean victim, and a miss with one or two dirty victim sectors. The walks also check the writeback order and the victim way. Separate simultaneous-request tests then fix the grant order: all five requesters at once, a store slot that arrives late behind an earlier one, and two stores that arrive together.

// File: rtl/l2t_pkg.sv
package l2t_pkg;

  localparam int NUM_SRC = 5;

  // Requester index; also the bit position in request and ack vectors.
  typedef enum logic [2:0] {
    SRC_IFETCH = 3'd0,
    SRC_LOAD   = 3'd1,
    SRC_ST0    = 3'd2,
    SRC_ST1    = 3'd3,
    SRC_SNOOP  = 3'd4
  } l2t_src_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } l2t_state_e;

  function automatic logic src_is_store(input l2t_src_e s);
    return (s == SRC_ST0) || (s == SRC_ST1);
  endfunction

endpackage

// File: rtl/l2t_arbiter.sv
module l2t_arbiter
  import l2t_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] blk,
  output logic [NUM_SRC-1:0] grant,
  output logic               grant_any,
  output l2t_src_e           grant_src
);

  logic [NUM_SRC-1:0] eff;
  logic               st1_first_q;  // store slot 1 became pending before slot 0

  assign eff = req & ~blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_first_q <= 1'b0;
    end else if (!req[SRC_ST0] && !req[SRC_ST1]) begin
      st1_first_q <= 1'b0;
    end else if (req[SRC_ST1] && !req[SRC_ST0]) begin
      st1_first_q <= 1'b1;
    end else if (req[SRC_ST0] && !req[SRC_ST1]) begin
      st1_first_q <= 1'b0;
    end
  end

  always_comb begin
    grant = '0;
    if (en) begin
      if (eff[SRC_SNOOP])                   grant[SRC_SNOOP] = 1'b1;
      else if (eff[SRC_LOAD])               grant[SRC_LOAD]  = 1'b1;
      else if (eff[SRC_ST0] && eff[SRC_ST1]) begin
        if (st1_first_q)                    grant[SRC_ST1]   = 1'b1;
        else                                grant[SRC_ST0]   = 1'b1;
      end
      else if (eff[SRC_ST0])                grant[SRC_ST0]   = 1'b1;
      else if (eff[SRC_ST1])                grant[SRC_ST1]   = 1'b1;
      else if (eff[SRC_IFETCH])             grant[SRC_IFETCH] = 1'b1;
    end
  end

  function automatic l2t_src_e f_encode(input logic [NUM_SRC-1:0] g);
    l2t_src_e r;
    r = SRC_IFETCH;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (g[i]) r = l2t_src_e'(i);
    end
    return r;
  endfunction

  assign grant_any = |grant;
  assign grant_src = f_encode(grant);

endmodule

// File: rtl/l2t_tag_store.sv
module l2t_tag_store #(
  parameter int SET_W = 6,
  parameter int TAG_W = 14,
  parameter int SECTS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SET_W-1:0]           rd_set,
  output logic [1:0][TAG_W-1:0]      rd_tag,
  output logic [1:0][SECTS-1:0]      rd_val,
  output logic [1:0][SECTS-1:0]      rd_mod,
  output logic                       rd_lru,
  input  logic                       wr_en,
  input  logic                       wr_way,
  input  logic [SET_W-1:0]           wr_set,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic [SECTS-1:0]           wr_val,
  input  logic [SECTS-1:0]           wr_mod,
  input  logic                       lru_we,
  input  logic [SET_W-1:0]           lru_set,
  input  logic                       lru_way
);

  localparam int SETS = 1 << SET_W;

  logic lru_q [SETS];

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SECTS-1:0] val_q [SETS];
    logic [SECTS-1:0] mod_q [SETS];
    logic             sel;

    assign sel = wr_en && (wr_way == (w != 0));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < SETS; i++) begin
          tag_q[i] <= '0;
          val_q[i] <= '0;
          mod_q[i] <= '0;
        end
      end else if (sel) begin
        tag_q[wr_set] <= wr_tag;
        val_q[wr_set] <= wr_val;
        mod_q[wr_set] <= wr_mod;
      end
    end

    assign rd_tag[w] = tag_q[rd_set];
    assign rd_val[w] = val_q[rd_set];
    assign rd_mod[w] = mod_q[rd_set];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) lru_q[i] <= 1'b0;
    end else if (lru_we) begin
      lru_q[lru_set] <= lru_way;
    end
  end

  assign rd_lru = lru_q[rd_set];

endmodule

// File: rtl/l2t_ctrl_top.sv
module l2t_ctrl_top
  import l2t_pkg::*;
#(
  parameter int TAG_W      = 14,
  parameter int SET_W      = 6,
  parameter int LINE_BYTES = 128,
  localparam int SECTS     = LINE_BYTES / 32,
  localparam int SECT_W    = $clog2(SECTS),
  localparam int ADDR_W    = TAG_W + SET_W + SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ifetch_req,
  input  logic [ADDR_W-1:0] ifetch_addr,
  output logic              ifetch_ack,
  input  logic              load_req,
  input  logic [ADDR_W-1:0] load_addr,
  output logic              load_ack,
  input  logic              store0_req,
  input  logic [ADDR_W-1:0] store0_addr,
  output logic              store0_ack,
  input  logic              store1_req,
  input  logic [ADDR_W-1:0] store1_addr,
  output logic              store1_ack,
  input  logic              snoop_req,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_ack,
  output logic              snoop_dirty,
  output logic              svc_valid,
  output logic              svc_way,
  output logic              svc_write,
  output logic [ADDR_W-1:0] svc_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              miss_valid,
  output logic              miss_write,
  output logic [ADDR_W-1:0] miss_addr
);

  // ---------------- address arithmetic ----------------
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [SET_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[SECT_W +: SET_W];
  endfunction

  function automatic logic [SECT_W-1:0] f_sect(input logic [ADDR_W-1:0] a);
    return a[SECT_W-1:0];
  endfunction

  function automatic logic [SECTS-1:0] f_bit(input logic [SECT_W-1:0] s);
    logic [SECTS-1:0] r;
    r = '0;
    r[s] = 1'b1;
    return r;
  endfunction

  function automatic logic [SECT_W-1:0] f_lowest(input logic [SECTS-1:0] m);
    logic [SECT_W-1:0] r;
    r = '0;
    for (int i = SECTS - 1; i >= 0; i--) begin
      if (m[i]) r = SECT_W'(i);
    end
    return r;
  endfunction

  // ---------------- arbitration ----------------
  l2t_state_e          state_q;
  logic [NUM_SRC-1:0]  ack_q;
  logic [NUM_SRC-1:0]  req_vec;
  logic [NUM_SRC-1:0]  grant;
  logic                grant_any;
  l2t_src_e            grant_src;

  assign req_vec = {snoop_req, store1_req, store0_req, load_req, ifetch_req};

  l2t_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (state_q == ST_IDLE),
    .req       (req_vec),
    .blk       (ack_q),
    .grant     (grant),
    .grant_any (grant_any),
    .grant_src (grant_src)
  );

  logic [ADDR_W-1:0] sel_addr;
  always_comb begin
    unique case (grant_src)
      SRC_LOAD:  sel_addr = load_addr;
      SRC_ST0:   sel_addr = store0_addr;
      SRC_ST1:   sel_addr = store1_addr;
      SRC_SNOOP: sel_addr = snoop_addr;
      default:   sel_addr = ifetch_addr;
    endcase
  end

  // ---------------- tag lookup ----------------
  logic [1:0][TAG_W-1:0] rd_tag;
  logic [1:0][SECTS-1:0] rd_val;
  logic [1:0][SECTS-1:0] rd_mod;
  logic                  rd_lru;

  logic                  wr_en, wr_way, lru_we, lru_way;
  logic [SET_W-1:0]      wr_set;
  logic [TAG_W-1:0]      wr_tag;
  logic [SECTS-1:0]      wr_val, wr_mod;

  logic [1:0]            line_match;
  logic                  lk_match_any, lk_way, lk_hit, lk_mod;
  logic                  vic_way;
  logic [SECTS-1:0]      vic_dirty;
  logic [SECT_W-1:0]     lk_sect;
  logic                  is_snoop, is_store;

  assign lk_sect = f_sect(sel_addr);

  for (genvar w = 0; w < 2; w++) begin : g_match
    assign line_match[w] = (rd_tag[w] == f_tag(sel_addr)) && (|rd_val[w]);
  end

  assign lk_match_any = |line_match;
  assign lk_way       = !line_match[0];
  assign lk_hit       = lk_match_any && rd_val[lk_way][lk_sect];
  assign lk_mod       = lk_hit && rd_mod[lk_way][lk_sect];
  assign vic_way      = lk_match_any ? lk_way : rd_lru;
  assign vic_dirty    = lk_match_any ? '0 : (rd_val[vic_way] & rd_mod[vic_way]);
  assign is_snoop     = (grant_src == SRC_SNOOP);
  assign is_store     = src_is_store(grant_src);

  // ---------------- pending miss ----------------
  l2t_src_e          p_src;
  logic [ADDR_W-1:0] p_addr;
  logic              p_way, p_keep, p_store;
  logic [SECTS-1:0]  p_mask, p_bval, p_bmod;
  logic [TAG_W-1:0]  p_vtag;

  // named events for the checker
  logic ev_hit, ev_snoop_hit, ev_miss_start, ev_fill, ev_wb;

  assign ev_hit        = (state_q == ST_IDLE) && grant_any && !is_snoop && lk_hit;
  assign ev_snoop_hit  = (state_q == ST_IDLE) && grant_any && is_snoop && lk_hit;
  assign ev_miss_start = (state_q == ST_IDLE) && grant_any && !is_snoop && !lk_hit;
  assign ev_wb         = (state_q == ST_FILL) && (|p_mask);
  assign ev_fill       = (state_q == ST_FILL) && !(|p_mask);

  l2t_tag_store #(
    .SET_W (SET_W),
    .TAG_W (TAG_W),
    .SECTS (SECTS)
  ) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_set  (f_set(sel_addr)),
    .rd_tag  (rd_tag),
    .rd_val  (rd_val),
    .rd_mod  (rd_mod),
    .rd_lru  (rd_lru),
    .wr_en   (wr_en),
    .wr_way  (wr_way),
    .wr_set  (wr_set),
    .wr_tag  (wr_tag),
    .wr_val  (wr_val),
    .wr_mod  (wr_mod),
    .lru_we  (lru_we),
    .lru_set (wr_set),
    .lru_way (lru_way)
  );

  // status and replacement updates
  always_comb begin
    wr_en   = 1'b0;
    wr_way  = lk_way;
    wr_set  = f_set(sel_addr);
    wr_tag  = rd_tag[lk_way];
    wr_val  = rd_val[lk_way];
    wr_mod  = rd_mod[lk_way];
    lru_we  = 1'b0;
    lru_way = !lk_way;
    if (ev_snoop_hit) begin
      wr_en  = 1'b1;
      wr_val = rd_val[lk_way] & ~f_bit(lk_sect);
      wr_mod = rd_mod[lk_way] & ~f_bit(lk_sect);
    end else if (ev_hit) begin
      lru_we = 1'b1;
      if (is_store) begin
        wr_en  = 1'b1;
        wr_mod = rd_mod[lk_way] | f_bit(lk_sect);
      end
    end else if (ev_fill) begin
      wr_en   = 1'b1;
      wr_way  = p_way;
      wr_set  = f_set(p_addr);
      wr_tag  = f_tag(p_addr);
      wr_val  = (p_keep ? p_bval : '0) | f_bit(f_sect(p_addr));
      wr_mod  = (p_keep ? p_bmod : '0) | (p_store ? f_bit(f_sect(p_addr)) : '0);
      lru_we  = 1'b1;
      lru_way = !p_way;
    end
  end

  // ---------------- sequencing and outputs ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ack_q       <= '0;
      snoop_dirty <= 1'b0;
      svc_valid   <= 1'b0;
      svc_way     <= 1'b0;
      svc_write   <= 1'b0;
      svc_addr    <= '0;
      wb_valid    <= 1'b0;
      wb_addr     <= '0;
      miss_valid  <= 1'b0;
      miss_write  <= 1'b0;
      miss_addr   <= '0;
      p_src       <= SRC_IFETCH;
      p_addr      <= '0;
      p_way       <= 1'b0;
      p_keep      <= 1'b0;
      p_store     <= 1'b0;
      p_mask      <= '0;
      p_bval      <= '0;
      p_bmod      <= '0;
      p_vtag      <= '0;
    end else begin
      ack_q       <= '0;
      snoop_dirty <= 1'b0;
      svc_valid   <= 1'b0;
      svc_write   <= 1'b0;
      wb_valid    <= 1'b0;
      miss_valid  <= 1'b0;
      miss_write  <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (grant_any && is_snoop) begin
          ack_q       <= grant;
          snoop_dirty <= lk_mod;
        end else if (ev_hit) begin
          ack_q     <= grant;
          svc_valid <= 1'b1;
          svc_way   <= lk_way;
          svc_write <= is_store;
          svc_addr  <= sel_addr;
        end else if (ev_miss_start) begin
          state_q <= ST_FILL;
          p_src   <= grant_src;
          p_addr  <= sel_addr;
          p_way   <= vic_way;
          p_keep  <= lk_match_any;
          p_store <= is_store;
          p_mask  <= vic_dirty;
          p_bval  <= rd_val[vic_way];
          p_bmod  <= rd_mod[vic_way];
          p_vtag  <= rd_tag[vic_way];
        end
      end else begin
        if (ev_wb) begin
          wb_valid <= 1'b1;
          wb_addr  <= {p_vtag, f_set(p_addr), f_lowest(p_mask)};
          p_mask   <= p_mask & ~f_bit(f_lowest(p_mask));
        end else begin
          miss_valid   <= 1'b1;
          miss_write   <= p_store;
          miss_addr    <= p_addr;
          ack_q[p_src] <= 1'b1;
          state_q      <= ST_IDLE;
        end
      end
    end
  end

  assign ifetch_ack = ack_q[SRC_IFETCH];
  assign load_ack   = ack_q[SRC_LOAD];
  assign store0_ack = ack_q[SRC_ST0];
  assign store1_ack = ack_q[SRC_ST1];
  assign snoop_ack  = ack_q[SRC_SNOOP];

endmodule

// File: rtl/l2t_checker.sv
module l2t_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] acks,
  input logic       svc_valid,
  input logic       svc_write,
  input logic       wb_valid,
  input logic       miss_valid,
  input logic       snoop_dirty,
  input logic       ev_fill,
  input logic       ev_wb
);

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acks)); // R3

  AST_HIT_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> (!wb_valid && !miss_valid)); // R2

  AST_WB_LEADS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> (wb_valid || miss_valid)); // R7

  AST_MISS_HAS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> ($countones(acks[3:0]) == 1)); // R5

  AST_FILL_ISSUES_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> miss_valid); // R5

  AST_WB_EVENT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb |=> (wb_valid && !miss_valid)); // R7

  AST_DIRTY_WITH_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_dirty |-> acks[4]); // R9

  AST_SNOOP_NO_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    acks[4] |-> (!svc_valid && !miss_valid && !wb_valid)); // R9

  AST_WRITE_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_write |-> (acks[2] || acks[3])); // R8

endmodule

bind l2t_ctrl_top l2t_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acks        ({snoop_ack, store1_ack, store0_ack, load_ack, ifetch_ack}),
  .svc_valid   (svc_valid),
  .svc_write   (svc_write),
  .wb_valid    (wb_valid),
  .miss_valid  (miss_valid),
  .snoop_dirty (snoop_dirty),
  .ev_fill     (ev_fill),
  .ev_wb       (ev_wb)
);

// File: tb/l2t_ctrl_top_tb.sv
module l2t_ctrl_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 3;
  localparam int SET_W = 2;
  localparam int LINE_BYTES = 64;
  localparam int AW = 6;  // tag[5:3] set[2:1] sector[0]

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [4:0]    reqv = '0;
  logic [AW-1:0] av [5];
  logic [4:0]    ackv;
  logic snoop_dirty, svc_valid, svc_way, svc_write, wb_valid, miss_valid, miss_write;
  logic [AW-1:0] svc_addr, wb_addr, miss_addr;

  l2t_ctrl_top #(.TAG_W(TAG_W), .SET_W(SET_W), .LINE_BYTES(LINE_BYTES)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ifetch_req(reqv[0]), .ifetch_addr(av[0]), .ifetch_ack(ackv[0]),
    .load_req(reqv[1]),   .load_addr(av[1]),   .load_ack(ackv[1]),
    .store0_req(reqv[2]), .store0_addr(av[2]), .store0_ack(ackv[2]),
    .store1_req(reqv[3]), .store1_addr(av[3]), .store1_ack(ackv[3]),
    .snoop_req(reqv[4]),  .snoop_addr(av[4]),  .snoop_ack(ackv[4]),
    .snoop_dirty(snoop_dirty),
    .svc_valid(svc_valid), .svc_way(svc_way), .svc_write(svc_write), .svc_addr(svc_addr),
    .wb_valid(wb_valid), .wb_addr(wb_addr),
    .miss_valid(miss_valid), .miss_write(miss_write), .miss_addr(miss_addr)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- reference state ----------------
  logic [2:0] mtag [4][2];
  logic [1:0] mval [4][2];
  logic [1:0] mmod [4][2];
  logic       mlru [4];

  int e_lat, e_way, e_nwb, e_match;
  bit e_svc, e_miss, e_dirty, e_write;
  logic [AW-1:0] e_wb [2];

  task automatic model_step(input int src, input logic [AW-1:0] a);
    int s, k, w;
    bit st;
    logic [2:0] t;
    s = int'(a[2:1]); k = int'(a[0]); t = a[5:3];
    st = (src == 2) || (src == 3);
    w = -1;
    for (int i = 1; i >= 0; i--)
      if (mtag[s][i] == t && mval[s][i] != 2'b00) w = i;
    e_match = (w >= 0);
    e_svc = 0; e_miss = 0; e_dirty = 0; e_nwb = 0; e_write = st; e_way = 0;
    if (src == 4) begin
      e_lat = 1;
      if (w >= 0 && mval[s][w][k]) begin
        e_dirty = mmod[s][w][k];
        mval[s][w][k] = 1'b0;
        mmod[s][w][k] = 1'b0;
      end
    end else if (w >= 0 && mval[s][w][k]) begin
      e_lat = 1; e_svc = 1; e_way = w;
      mlru[s] = (w == 0);
      if (st) mmod[s][w][k] = 1'b1;
    end else begin
      e_miss = 1;
      if (w < 0) begin
        w = int'(mlru[s]);
        for (int q = 0; q < 2; q++)
          if (mval[s][w][q] && mmod[s][w][q]) begin
            e_wb[e_nwb] = {mtag[s][w], a[2:1], q[0]};
            e_nwb++;
          end
        mtag[s][w] = t; mval[s][w] = 2'b00; mmod[s][w] = 2'b00;
      end
      e_way = w;
      mval[s][w][k] = 1'b1;
      mmod[s][w][k] = st;
      mlru[s] = (w == 0);
      e_lat = 2 + e_nwb;
    end
  endtask

  // ---------------- single request with full comparison ----------------
  task automatic run_req(input int src, input logic [AW-1:0] a);
    int lat, nwb;
    bit got, g_svc, g_way, g_wr, g_miss, g_mw, g_dirty;
    logic [AW-1:0] g_wb [2];
    logic [AW-1:0] g_maddr, g_saddr;
    model_step(src, a);
    @(negedge clk);
    av[src] = a;
    reqv[src] = 1'b1;
    got = 0; nwb = 0; lat = 0; g_miss = 0; g_mw = 0; g_maddr = '0;
    g_svc = 0; g_way = 0; g_wr = 0; g_dirty = 0; g_saddr = '0;
    for (int c = 1; c <= 20 && !got; c++) begin
      @(negedge clk);
      if (wb_valid) begin
        if (nwb < 2) g_wb[nwb] = wb_addr;
        nwb++;
      end
      if (ackv[src]) begin
        got = 1; lat = c;
        g_svc = svc_valid; g_way = svc_way; g_wr = svc_write; g_saddr = svc_addr;
        g_miss = miss_valid; g_mw = miss_write; g_maddr = miss_addr;
        g_dirty = snoop_dirty;
        reqv[src] = 1'b0;
      end
    end
    reqv[src] = 1'b0;
    if (src == 4) begin
      check("R9 snoop latency", lat == 1, lat, 1);
      check("R9 snoop dirty", g_dirty == e_dirty, int'(g_dirty), int'(e_dirty));
      check("R9 snoop no svc/miss/wb", !g_svc && !g_miss && nwb == 0, nwb, 0);
    end else if (e_svc) begin
      check("R2 hit latency", lat == 1, lat, 1);
      check("R2 hit service", g_svc && !g_miss && nwb == 0 && g_saddr == a, int'(g_saddr), int'(a));
      check("R6 hit way", g_way == e_way[0], int'(g_way), e_way);
      check("R8 svc_write", g_wr == e_write, int'(g_wr), int'(e_write));
    end else begin
      if (e_match) check("R10 sector-miss latency, no writeback", lat == 2 && nwb == 0, lat, 2);
      else         check("R5 R11 miss latency", lat == e_lat, lat, e_lat);
      check("R5 miss request", g_miss && !g_svc && g_maddr == a, int'(g_maddr), int'(a));
      check("R8 miss_write", g_mw == e_write, int'(g_mw), int'(e_write));
      check("R7 writeback count", nwb == e_nwb, nwb, e_nwb);
      for (int i = 0; i < e_nwb && i < nwb; i++)
        check("R7 R6 writeback address", g_wb[i] == e_wb[i], int'(g_wb[i]), int'(e_wb[i]));
    end
  endtask

  // ---------------- several requests at once ----------------
  task automatic run_multi(input string tag, input logic [4:0] first, input logic [4:0] late,
                           input int n, input int o0, input int o1, input int o2,
                           input int o3, input int o4);
    int ord [5];
    int exp_o [5];
    int cnt;
    exp_o[0] = o0; exp_o[1] = o1; exp_o[2] = o2; exp_o[3] = o3; exp_o[4] = o4;
    for (int i = 0; i < n; i++) model_step(exp_o[i], av[exp_o[i]]);
    @(negedge clk);
    reqv = first;
    cnt = 0;
    for (int c = 1; c <= 15 && cnt < n; c++) begin
      @(negedge clk);
      check({tag, " one ack per cycle"}, $countones(ackv) <= 1, $countones(ackv), 1);
      for (int s = 0; s < 5; s++)
        if (ackv[s]) begin
          if (cnt < 5) ord[cnt] = s;
          cnt++;
          reqv[s] = 1'b0;
        end
      if (c == 1) reqv = reqv | late;
    end
    reqv = '0;
    check({tag, " ack count"}, cnt == n, cnt, n);
    for (int i = 0; i < n && i < cnt; i++)
      check({tag, " grant order"}, ord[i] == exp_o[i], ord[i], exp_o[i]);
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      mlru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        mtag[s][w] = '0; mval[s][w] = '0; mmod[s][w] = '0;
      end
    end
    for (int i = 0; i < 5; i++) av[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check("R1 reset acks", ackv == 5'b0, int'(ackv), 0);
    check("R1 reset bus/svc", !svc_valid && !wb_valid && !miss_valid && !snoop_dirty,
          int'({svc_valid, wb_valid, miss_valid, snoop_dirty}), 0);
    // R1: first touch always misses
    run_req(1, 6'd0);
    check("R1 first access missed", e_miss, int'(e_miss), 1);

    // sweep 1: instruction fetches over every sector address
    for (int i = 0; i < 64; i++) run_req(0, AW'(i));
    // sweep 2: loads in reverse order
    for (int i = 63; i >= 0; i--) run_req(1, AW'(i));
    // sweep 3: stores alternating slots on a scrambled order
    for (int i = 0; i < 64; i++) run_req(2 + (i % 2), AW'((i * 37 + 11) % 64));
    // sweep 4: mixed stream including snoops
    for (int i = 0; i < 120; i++) run_req(i % 5, AW'((i * 13 + 7) % 64));
    // targeted dirty line: two modified sectors then a conflicting pair of lines
    run_req(2, 6'b110_01_0);
    run_req(3, 6'b110_01_1);
    run_req(1, 6'b001_01_0);
    run_req(1, 6'b010_01_0);
    run_req(1, 6'b011_01_1);
    // snoop on a modified sector, then again on the now invalid one
    run_req(2, 6'b101_10_1);
    run_req(4, 6'b101_10_1);
    run_req(4, 6'b101_10_1);

    // priority: prefill four hits in distinct sets, snoop to an absent line
    run_req(0, 6'b000_00_0);
    run_req(1, 6'b001_01_0);
    run_req(2, 6'b010_10_1);
    run_req(3, 6'b011_11_0);
    run_req(4, 6'b111_00_1);
    av[4] = 6'b111_00_1;
    run_multi("R3", 5'b11111, 5'b00000, 5, 4, 1, 2, 3, 0);
    // store age: slot 1 waits behind the load, slot 0 arrives one cycle later
    run_multi("R4 age", 5'b01010, 5'b00100, 3, 1, 3, 2, 0, 0);
    // store tie: both slots at once
    run_multi("R4 tie", 5'b01100, 5'b00000, 2, 2, 3, 0, 0, 0);
    // R4: load before stores when all three arrive together
    run_multi("R4 load first", 5'b01110, 5'b00000, 3, 1, 2, 3, 0, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule